// File: doc/BRIEF.md
# Multi-mode counter unit

This block wraps a single 24-bit presettable up-counter and can use it in four ways: as a diagnostic register, as a gated event scaler, as a pulse-width meter and as a periodic pulse generator. It is controlled through a bank of sixteen single-bit control signals and reports its state through an 8-bit status word. Each control write changes one signal, chosen by an index, to the level given with the write.

The count input, gate and clock from outside arrive asynchronously. The block synchronises them and works on their rising edges or levels. Internal timebases are divided down from the system clock. The generator reloads its preset each time the counter wraps, so its period is set by the preset. In software mode its output follows a control level instead.

Top module: `multimode_counter_unit`

## Requirements
- R1: A control write takes `ctl_data[3:0]` as the index of one control signal and `ctl_data[4]` as its new level; no other control signal changes. Index map: 0/1 mode bits (mode = {sig1,sig0}: 0 register, 1 scaler, 2 width, 3 generator), 2/3 timebase select, 4 external timebase, 5 oscillator enable, 6 generator enable, 7 output enable, 8 software gate, 9 external-gate select, 10 external-count select, 11 overflow inhibit, 12 software pulse level, 13 software generator mode, 14/15 user flags.
- R2: `status` shows, one cycle behind the state: bit0 overflow flag, bit1 selected gate level, bit2 `pulse_out`, bits4:3 mode, bit5 oscillator enable, bit6 counting inhibited (inhibit set and overflow flag set), bit7 OR of the two user flags.
- R3: `data_wr` stores `data_in` as the preset and `load_stb` copies the preset into the counter, which `count_val` then shows unchanged. In register mode the counter does not count.
- R4: In scaler mode each count event adds one while the gate is high. The event is a `sw_count` strobe, or an `ext_count` rising edge when signal 10 is set. The gate is software gate signal 8, or `ext_gate` when signal 9 is set. Events while the gate is low are ignored.
- R5: A count at 0xFFFFFF wraps the counter to 0 and sets the overflow flag. The flag stays set until `clr_stb`, which also zeroes the counter.
- R6: With overflow inhibit set, in every mode other than generator, count events are ignored while the overflow flag is set.
- R7: In width mode the counter adds one per timebase tick while the gate is high. With the oscillator enabled, timebase select s (0..3) gives a tick every 200·2^s ns. With signal 4 set, each `ext_clk` rising edge is a tick.
- R8: In generator mode, with oscillator, generator and output enable set, the counter counts ticks and reloads the preset at the wrap. `pulse_out` is high for one clock per wrap, with period (2^24 − preset) ticks.
- R9: With output enable clear, `pulse_out` is low on the next cycle.
- R10: With software generator mode set in generator mode, `pulse_out` equals output enable AND software pulse level, one cycle after the control write.
- R11: After reset all control signals are inactive and `count_val`, `status` and `pulse_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 5 | Index [3:0] and level [4] of one control signal |
| data_wr | input | 1 | Preset write strobe |
| data_in | input | 24 | Preset value |
| load_stb | input | 1 | Copy preset into counter |
| clr_stb | input | 1 | Zero counter and overflow flag |
| sw_count | input | 1 | Software count strobe |
| ext_count | input | 1 | Asynchronous count input |
| ext_gate | input | 1 | Asynchronous gate |
| ext_clk | input | 1 | Asynchronous external timebase |
| pulse_out | output | 1 | Generator output |
| status | output | 8 | Status word |
| count_val | output | 24 | Counter value |

## Verification
The scaler gets bursts of software strobes and external edges, each with its own gate source held high and then low. This separates event-source selection from gate selection. Width mode is run with a gated external clock and with three internal timebases on equal gate windows, and the ratio of the counts shows the divider selection. Preset loads just below the wrap separate plain wrap-around, the inhibited stop, and the generator's preset-derived period. The software generator is toggled while the hardware counter keeps wrapping, which shows that the output source really switches.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  typedef enum logic [1:0] {
    MODE_REG    = 2'd0,
    MODE_SCALER = 2'd1,
    MODE_WIDTH  = 2'd2,
    MODE_GEN    = 2'd3
  } mcu_mode_e;

  localparam int CI_MODE0    = 0;
  localparam int CI_MODE1    = 1;
  localparam int CI_FS0      = 2;
  localparam int CI_FS1      = 3;
  localparam int CI_EXT_TB   = 4;
  localparam int CI_OSC_EN   = 5;
  localparam int CI_PG_EN    = 6;
  localparam int CI_OUT_EN   = 7;
  localparam int CI_SW_GATE  = 8;
  localparam int CI_GATE_EXT = 9;
  localparam int CI_CNT_EXT  = 10;
  localparam int CI_INH_OVF  = 11;
  localparam int CI_SW_PG    = 12;
  localparam int CI_PG_SWMD  = 13;
  localparam int CI_USER0    = 14;
  localparam int CI_USER1    = 15;
endpackage

// File: rtl/mcu_ctrl_reg.sv
module mcu_ctrl_reg #(
  parameter int N_CTRL = 16,
  localparam int SEL_W = $clog2(N_CTRL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [SEL_W:0]    wr_data,
  output logic [N_CTRL-1:0] ctrl_q
);
  logic [SEL_W-1:0] sel;
  logic             lvl;
  assign sel = wr_data[SEL_W-1:0];
  assign lvl = wr_data[SEL_W];

  for (genvar i = 0; i < N_CTRL; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[i] <= 1'b0;
      end else if (wr && (sel == SEL_W'(i))) begin
        ctrl_q[i] <= lvl;
      end
    end
  end
endmodule

// File: rtl/mcu_sync_edge.sv
module mcu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else begin
      sr <= {sr[STAGES-1:0], async_in};
    end
  end

  assign level = sr[STAGES-1];
  assign rise  = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/mcu_timebase.sv
module mcu_timebase #(
  parameter int CLK_NS  = 4,
  parameter int BASE_NS = 200,
  parameter int FS_W    = 2,
  localparam int BASE_DIV = BASE_NS / CLK_NS,
  localparam int BW       = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1,
  localparam int PS_W     = (1 << FS_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [FS_W-1:0] fs,
  input  logic            use_ext,
  input  logic            ext_rise,
  output logic            tick
);
  logic [BW-1:0]   base_q;
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;
  logic            base_end;
  logic            tick_int;

  assign base_end = (base_q == BW'(BASE_DIV - 1));
  assign mask     = ~({PS_W{1'b1}} << fs);
  assign tick_int = en && base_end && ((ps_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      base_q <= '0;
      ps_q   <= '0;
    end else if (base_end) begin
      base_q <= '0;
      ps_q   <= ps_q + 1'b1;
    end else begin
      base_q <= base_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= 1'b0;
    end else begin
      tick <= use_ext ? ext_rise : tick_int;
    end
  end
endmodule

// File: rtl/mcu_counter.sv
module mcu_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  input  logic             inc,
  input  logic             inhibit,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      ovf  <= 1'b0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (clr) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (load) begin
        cnt <= preset;
      end else if (inc && !(inhibit && ovf)) begin
        if (cnt == CNT_MAX) begin
          ovf  <= 1'b1;
          wrap <= 1'b1;
          cnt  <= reload ? preset : '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/multimode_counter_unit.sv
module multimode_counter_unit
  import mcu_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int N_CTRL      = 16,
  parameter int CLK_NS      = 4,
  parameter int BASE_NS     = 200,
  parameter int FS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctl_wr,
  input  logic [$clog2(N_CTRL):0]   ctl_data,
  input  logic                      data_wr,
  input  logic [CNT_W-1:0]          data_in,
  input  logic                      load_stb,
  input  logic                      clr_stb,
  input  logic                      sw_count,
  input  logic                      ext_count,
  input  logic                      ext_gate,
  input  logic                      ext_clk,
  output logic                      pulse_out,
  output logic [7:0]                status,
  output logic [CNT_W-1:0]          count_val
);
  logic [N_CTRL-1:0] ctrl_q;
  logic [CNT_W-1:0]  preset_q;
  logic              count_rise, gate_lvl_ext, clk_rise;
  logic              unused_lvl_a, unused_lvl_c;
  logic              tb_tick;
  logic              ovf_flag, wrap_evt;
  mcu_mode_e         mode;
  logic              gate_lvl, cnt_evt, inc, inhibit, reload, pulse_nxt;

  mcu_ctrl_reg #(.N_CTRL(N_CTRL)) u_ctrl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wr_data(ctl_data), .ctrl_q(ctrl_q)
  );

  mcu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_cnt (
    .clk(clk), .rst(rst), .async_in(ext_count), .level(unused_lvl_a), .rise(count_rise)
  );
  mcu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_gate (
    .clk(clk), .rst(rst), .async_in(ext_gate), .level(gate_lvl_ext), .rise()
  );
  mcu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .async_in(ext_clk), .level(unused_lvl_c), .rise(clk_rise)
  );

  mcu_timebase #(.CLK_NS(CLK_NS), .BASE_NS(BASE_NS), .FS_W(FS_W)) u_tb (
    .clk(clk), .rst(rst),
    .en(ctrl_q[CI_OSC_EN]),
    .fs(ctrl_q[CI_FS0 +: FS_W]),
    .use_ext(ctrl_q[CI_EXT_TB]),
    .ext_rise(clk_rise),
    .tick(tb_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q <= '0;
    end else if (data_wr) begin
      preset_q <= data_in;
    end
  end

  assign mode     = mcu_mode_e'(ctrl_q[CI_MODE1:CI_MODE0]);
  assign gate_lvl = ctrl_q[CI_GATE_EXT] ? gate_lvl_ext : ctrl_q[CI_SW_GATE];
  assign cnt_evt  = ctrl_q[CI_CNT_EXT] ? count_rise : sw_count;

  always_comb begin
    inc = 1'b0;
    unique case (mode)
      MODE_REG:    inc = 1'b0;
      MODE_SCALER: inc = gate_lvl & cnt_evt;
      MODE_WIDTH:  inc = gate_lvl & tb_tick;
      MODE_GEN:    inc = ctrl_q[CI_OSC_EN] & ctrl_q[CI_PG_EN] & tb_tick;
      default:     inc = 1'b0;
    endcase
  end

  assign reload  = (mode == MODE_GEN);
  assign inhibit = ctrl_q[CI_INH_OVF] && (mode != MODE_GEN);

  mcu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_stb), .load(load_stb), .preset(preset_q),
    .inc(inc), .inhibit(inhibit), .reload(reload),
    .cnt(count_val), .ovf(ovf_flag), .wrap(wrap_evt)
  );

  assign pulse_nxt = ctrl_q[CI_OUT_EN] && (mode == MODE_GEN) &&
                     (ctrl_q[CI_PG_SWMD] ? ctrl_q[CI_SW_PG]
                                         : (ctrl_q[CI_OSC_EN] & ctrl_q[CI_PG_EN] & wrap_evt));

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_out <= 1'b0;
      status    <= '0;
    end else begin
      pulse_out <= pulse_nxt;
      status    <= {ctrl_q[CI_USER1] | ctrl_q[CI_USER0],
                    inhibit & ovf_flag,
                    ctrl_q[CI_OSC_EN],
                    mode,
                    pulse_out,
                    gate_lvl,
                    ovf_flag};
    end
  end
endmodule

// File: rtl/mcu_checker.sv
module mcu_checker
  import mcu_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int N_CTRL = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [N_CTRL-1:0] ctrl,
  input logic              clr_stb,
  input logic              load_stb,
  input logic [CNT_W-1:0]  preset,
  input logic [CNT_W-1:0]  count_val,
  input logic              ovf,
  input logic              pulse_out
);
  assert_load_copies_preset_R3: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !clr_stb) |=> (count_val == $past(preset)));

  assert_reg_mode_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl[CI_MODE1:CI_MODE0] == 2'd0 && !clr_stb && !load_stb) |=> $stable(count_val));

  assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> (count_val == '0 && !ovf));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_stb) |=> ovf);

  assert_inhibit_freezes_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl[CI_INH_OVF] && ovf && ctrl[CI_MODE1:CI_MODE0] != 2'd3 && !clr_stb && !load_stb)
      |=> $stable(count_val));

  assert_outen_gates_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl[CI_OUT_EN] |=> !pulse_out);
endmodule

bind multimode_counter_unit mcu_checker #(.CNT_W(CNT_W), .N_CTRL(N_CTRL)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl_q), .clr_stb(clr_stb), .load_stb(load_stb),
  .preset(preset_q), .count_val(count_val), .ovf(ovf_flag), .pulse_out(pulse_out)
);

// File: tb/multimode_counter_unit_test.sv
`timescale 1ns/1ps
module multimode_counter_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 0, data_wr = 0, load_stb = 0, clr_stb = 0, sw_count = 0;
  logic [4:0]  ctl_data = '0;
  logic [23:0] data_in = '0;
  logic        ext_count = 0, ext_gate = 0, ext_clk = 0;
  logic        pulse_out;
  logic [7:0]  status;
  logic [23:0] count_val;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  multimode_counter_unit uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data), .data_wr(data_wr),
    .data_in(data_in), .load_stb(load_stb), .clr_stb(clr_stb), .sw_count(sw_count),
    .ext_count(ext_count), .ext_gate(ext_gate), .ext_clk(ext_clk),
    .pulse_out(pulse_out), .status(status), .count_val(count_val)
  );

  // kind 0: count_val (+/- tol), 1: status bit act, 2: pulse_out, 3: given value act
  typedef struct { string req; int kind; int exp; int act; int tol; } item_t;
  item_t sb_q[$];
  event  sb_ev;

  task automatic expect_item(string req, int kind, int exp, int act, int tol);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp; it.act = act; it.tol = tol;
    sb_q.push_back(it);
    ->sb_ev;
    #0;
  endtask

  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        int    got;
        bit    ok;
        it = sb_q.pop_front();
        case (it.kind)
          0: got = int'(count_val);
          1: got = int'(status[it.act]);
          2: got = int'(pulse_out);
          default: got = it.act;
        endcase
        ok = (got >= it.exp - it.tol) && (got <= it.exp + it.tol);
        checks++;
        if (!ok) begin
          fails++;
          $display("FAIL %s: actual=%0d expected=%0d", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(int idx, bit lvl);
    @(negedge clk); ctl_data = {lvl, 4'(idx)}; ctl_wr = 1;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic set_preset_load(logic [23:0] v);
    @(negedge clk); data_in = v; data_wr = 1;
    @(negedge clk); data_wr = 0; load_stb = 1;
    @(negedge clk); load_stb = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_stb = 1;
    @(negedge clk); clr_stb = 0;
  endtask

  task automatic sw_counts(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sw_count = 1;
      @(negedge clk); sw_count = 0;
    end
    idle(2);
  endtask

  task automatic ext_pulses(int n, bit on_clk);
    for (int i = 0; i < n; i++) begin
      if (on_clk) ext_clk = 1; else ext_count = 1;
      idle(4);
      if (on_clk) ext_clk = 0; else ext_count = 0;
      idle(4);
    end
    idle(4);
  endtask

  task automatic set_mode(int m);
    ctl(0, m[0]); ctl(1, m[1]);
  endtask

  initial begin
    int wait_n, period, npulse;
    idle(5);
    rst = 0;
    idle(3);
    // R11 reset state
    expect_item("R11 count", 0, 0, 0, 0);
    expect_item("R11 status", 3, 0, int'(status), 0);
    expect_item("R11 pulse", 2, 0, 0, 0);

    // R1 single-signal writes seen through mode field; R2 status layout
    ctl(0, 1); ctl(1, 1); idle(2);
    expect_item("R1 mode=3", 3, 3, int'(status[4:3]), 0);
    ctl(0, 0); idle(2);
    expect_item("R1 mode=2", 3, 2, int'(status[4:3]), 0);
    ctl(14, 1); idle(2);
    expect_item("R2 user flag bit7", 1, 1, 7, 0);
    expect_item("R1 mode kept", 3, 2, int'(status[4:3]), 0);
    ctl(14, 0); ctl(1, 0); idle(2);
    expect_item("R2 bit7 clear", 1, 0, 7, 0);

    // R3 register mode
    set_preset_load(24'hA5C3F0); idle(1);
    expect_item("R3 readback", 0, 24'hA5C3F0, 0, 0);
    ctl(8, 1);
    sw_counts(3);
    expect_item("R3 no count in register mode", 0, 24'hA5C3F0, 0, 0);
    do_clear(); idle(1);
    expect_item("R5 clear", 0, 0, 0, 0);

    // R4 scaler
    set_mode(1);
    sw_counts(5);
    expect_item("R4 sw count gated on", 0, 5, 0, 0);
    expect_item("R2 gate bit", 1, 1, 1, 0);
    ctl(8, 0);
    sw_counts(4);
    expect_item("R4 gate low ignores", 0, 5, 0, 0);
    ctl(10, 1); ctl(8, 1);
    ext_pulses(4, 0);
    expect_item("R4 ext count", 0, 9, 0, 0);
    ctl(9, 1);
    ext_pulses(2, 0);
    expect_item("R4 ext gate low ignores", 0, 9, 0, 0);
    ext_gate = 1; idle(4);
    ext_pulses(3, 0);
    ext_gate = 0; idle(4);
    expect_item("R4 ext gate high", 0, 12, 0, 0);
    ctl(9, 0); ctl(10, 0);

    // R5 overflow wrap and sticky flag
    set_preset_load(24'hFFFFFE);
    sw_counts(3);
    expect_item("R5 wrap", 0, 1, 0, 0);
    expect_item("R5 ovf flag", 1, 1, 0, 0);
    sw_counts(2);
    expect_item("R5 ovf sticky", 1, 1, 0, 0);
    do_clear(); idle(2);
    expect_item("R5 ovf cleared", 1, 0, 0, 0);

    // R6 inhibit
    ctl(11, 1);
    set_preset_load(24'hFFFFFE);
    sw_counts(3);
    expect_item("R6 stop at wrap", 0, 0, 0, 0);
    expect_item("R6 inhibited status", 1, 1, 6, 0);
    sw_counts(2);
    expect_item("R6 further ignored", 0, 0, 0, 0);
    do_clear(); ctl(11, 0); ctl(8, 0);

    // R7 width mode
    set_mode(2);
    ctl(4, 1); ctl(9, 1);
    ext_gate = 1; idle(4);
    ext_pulses(7, 1);
    ext_gate = 0; idle(4);
    ext_pulses(3, 1);
    expect_item("R7 ext timebase", 0, 7, 0, 0);
    ctl(4, 0); ctl(9, 0); do_clear();
    ctl(5, 1);
    ctl(8, 1); idle(3200); ctl(8, 0); idle(2);
    expect_item("R7 200ns", 0, 64, 0, 1);
    do_clear(); ctl(2, 1);
    ctl(8, 1); idle(3200); ctl(8, 0); idle(2);
    expect_item("R7 400ns", 0, 32, 0, 1);
    do_clear(); ctl(3, 1);
    ctl(8, 1); idle(3200); ctl(8, 0); idle(2);
    expect_item("R7 1600ns", 0, 8, 0, 1);
    do_clear(); ctl(2, 0); ctl(3, 0);

    // R8 hardware generator, preset 2^24-5 -> 5 ticks of 50 clocks
    set_mode(3);
    set_preset_load(24'hFFFFFB);
    ctl(6, 1); ctl(7, 1);
    wait_n = 0;
    while (pulse_out !== 1'b1 && wait_n < 2000) begin idle(1); wait_n++; end
    expect_item("R8 first pulse seen", 3, 1, int'(wait_n < 2000), 0);
    idle(1);
    expect_item("R8 pulse one clock", 2, 0, 0, 0);
    period = 1;
    while (pulse_out !== 1'b1 && period < 2000) begin idle(1); period++; end
    expect_item("R8 period", 3, 250, period, 0);
    expect_item("R5 ovf set by generator", 1, 1, 0, 0);

    // R9 output enable clear
    ctl(7, 0);
    npulse = 0;
    for (int i = 0; i < 600; i++) begin idle(1); if (pulse_out) npulse++; end
    expect_item("R9 no pulses", 3, 0, npulse, 0);

    // R10 software generator
    ctl(13, 1); ctl(7, 1);
    ctl(12, 1); idle(1);
    expect_item("R10 follows level high", 2, 1, 0, 0);
    idle(300);
    expect_item("R10 holds high", 2, 1, 0, 0);
    ctl(12, 0); idle(1);
    expect_item("R10 follows level low", 2, 0, 0, 0);
    ctl(12, 1); ctl(7, 0); idle(1);
    expect_item("R10 out enable gates", 2, 0, 0, 0);

    idle(2);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule